// File: doc/BRIEF.md
# Shader Program Store and Sequencer

This block keeps a small store of 128-bit vertex-program instructions and chooses, one per cycle, which of them the execution datapath sees next. A host fills the store through a three-command interface: one command places the load pointer, one delivers a single 32-bit word of an instruction, and one records the index at which execution will begin. The load pointer moves on by itself after every complete instruction, so a run of consecutive instructions needs only one pointer command.

A pulse on the run input starts a program at the recorded entry index, which need not be zero. Code stored below the entry point, such as subroutines, is reached only by jump or call. While running, the block presents the current instruction and its index. The datapath returns a condition-pass flag in the same cycle. The sequencer resolves jumps, calls and returns with a four-entry return-address stack. It stops after an instruction whose final-instruction bit is set, or on a stack error.

Top module: `shprog_seq`

## Requirements
- R1: After reset, `running`, `upload_err` and `stack_err` are all 0.
- R2: `cmd_op` encodes 0 = place load pointer (`cmd_data[6:0]`), 1 = deliver word, 2 = set entry index (`cmd_data[5:0]`), 3 = no effect. An instruction takes four word commands, sent lowest word first. Word k occupies `inst_word[32k+31:32k]`. The instruction is written only when the fourth word arrives.
- R3: The place-pointer command loads the pointer and discards any partly delivered instruction, so the next word counts as word 0. Each written instruction advances the pointer by one.
- R4: The cycle after an accepted `run_start`, `running` is 1 and `inst_idx` equals the entry index. Without control transfer, the index then rises by one per cycle.
- R5: An instruction with bit 96 (bit 0 of word 3) set is presented for one cycle, and `running` is 0 the next cycle.
- R6: The opcode is {bit 0, bits 63:60}. Value 0x09 is a jump to the index in bits 71:66 (word 2 bits 7:2). A jump is taken when bit 14 (condition test enable) is 0, or when `cond_pass` is 1. Otherwise the sequencer falls through to the next index. Backward targets are allowed.
- R7: Opcode 0x0B is a call: when taken, it pushes the next index and goes to the target. Opcode 0x0C is a return: when taken, it pops and resumes there. Both use the same condition gate as the jump. Calls nest four deep without error.
- R8: A taken call with four entries stacked, or a taken return with none, sets `stack_err`. `running` is 0 the next cycle. `stack_err` stays set until reset.
- R9: Completing an instruction while the pointer is at 64 or above writes nothing and sets `upload_err`, which stays set until reset.
- R10: Every host command is ignored while `running` is 1, and also in the cycle in which `run_start` is asserted.
- R11: When the final-instruction bit and a taken jump or call occur in the same instruction, the run ends and no transfer happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Host command code |
| cmd_data | input | 32 | Host command payload |
| run_start | input | 1 | Start-of-program pulse |
| cond_pass | input | 1 | Condition result for the presented instruction |
| running | output | 1 | Program in progress |
| inst_idx | output | 6 | Index of the presented instruction |
| inst_word | output | 128 | Presented instruction |
| upload_err | output | 1 | Sticky upload-range error |
| stack_err | output | 1 | Sticky return-stack error |

## Verification
Host commands and the start of a run can arrive in the same cycle. The bench asserts `run_start` together with an entry-index command, and later sends pointer, word and entry commands while a nested-call program runs. Both are judged by running again afterwards: the entry index and the stored words must be unchanged. The store contents are swept over every index, with expected words computed from the index.

// File: rtl/shprog_pkg.sv
package shprog_pkg;
  localparam int WORD_W = 32;
  localparam int INST_W = 128;

  typedef enum logic [1:0] {
    CMD_SET_LOAD  = 2'd0,
    CMD_PUT_WORD  = 2'd1,
    CMD_SET_ENTRY = 2'd2,
    CMD_IDLE      = 2'd3
  } host_cmd_e;

  localparam logic [4:0] SOP_JUMP   = 5'h09;
  localparam logic [4:0] SOP_CALL   = 5'h0B;
  localparam logic [4:0] SOP_RETURN = 5'h0C;

  localparam int TGT_LSB = 66;

  function automatic logic [4:0] sop_of(input logic [INST_W-1:0] i);
    return {i[0], i[63:60]};
  endfunction

  function automatic logic cond_enabled(input logic [INST_W-1:0] i);
    return i[14];
  endfunction

  function automatic logic is_final(input logic [INST_W-1:0] i);
    return i[96];
  endfunction
endpackage

// File: rtl/shprog_loader.sv
module shprog_loader
  import shprog_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [31:0]       cmd_data,
  input  logic              lock,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [INST_W-1:0] wr_data,
  output logic [IDX_W-1:0]  entry_idx,
  output logic              upload_err
);
  host_cmd_e     op;
  logic          take;
  logic [IDX_W:0] ptr;
  logic [1:0]    wcnt;
  logic [95:0]   hold;
  logic          ptr_oob;
  logic          fourth;

  assign op      = host_cmd_e'(cmd_op);
  assign take    = cmd_valid & ~lock;
  assign ptr_oob = ptr >= (IDX_W+1)'(DEPTH);
  assign fourth  = take && (op == CMD_PUT_WORD) && (wcnt == 2'd3);
  assign wr_en   = fourth & ~ptr_oob;
  assign wr_idx  = ptr[IDX_W-1:0];
  assign wr_data = {cmd_data, hold};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= '0;
      wcnt       <= '0;
      hold       <= '0;
      entry_idx  <= '0;
      upload_err <= 1'b0;
    end else if (take) begin
      unique case (op)
        CMD_SET_LOAD: begin
          ptr  <= cmd_data[IDX_W:0];
          wcnt <= '0;
        end
        CMD_PUT_WORD: begin
          if (wcnt == 2'd3) begin
            wcnt <= '0;
            if (ptr_oob) upload_err <= 1'b1;
            else         ptr        <= ptr + 1'b1;
          end else begin
            hold[{wcnt, 5'b0} +: 32] <= cmd_data;
            wcnt <= wcnt + 1'b1;
          end
        end
        CMD_SET_ENTRY: entry_idx <= cmd_data[IDX_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shprog_imem.sv
module shprog_imem
  import shprog_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [INST_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [INST_W-1:0] rd_data
);
  logic [INST_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/shprog_ras.sv
module shprog_ras #(
  parameter int RAS_DEPTH = 4,
  parameter int IDX_W     = 6,
  localparam int LVL_W    = $clog2(RAS_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [IDX_W-1:0] push_data,
  output logic [IDX_W-1:0] top_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [IDX_W-1:0] stk [RAS_DEPTH];

  assign top_data = stk[0];
  assign full     = level == LVL_W'(RAS_DEPTH);
  assign empty    = level == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 level <= '0;
    else if (clr)               level <= '0;
    else if (push && !full)     level <= level + 1'b1;
    else if (pop && !empty)     level <= level - 1'b1;
  end

  for (genvar g = 0; g < RAS_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stk[g] <= '0;
      else if (clr) stk[g] <= '0;
      else if (push) begin
        if (g == 0) stk[g] <= push_data;
        else        stk[g] <= stk[(g == 0) ? 0 : g-1];
      end else if (pop) begin
        if (g == RAS_DEPTH-1) stk[g] <= '0;
        else                  stk[g] <= stk[(g == RAS_DEPTH-1) ? g : g+1];
      end
    end
  end
endmodule

// File: rtl/shprog_seq.sv
module shprog_seq
  import shprog_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int RAS_DEPTH = 4,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int LVL_W    = $clog2(RAS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [31:0]       cmd_data,
  input  logic              run_start,
  input  logic              cond_pass,
  output logic              running,
  output logic [IDX_W-1:0]  inst_idx,
  output logic [INST_W-1:0] inst_word,
  output logic              upload_err,
  output logic              stack_err
);
  logic              commit;
  logic [IDX_W-1:0]  wr_idx;
  logic [INST_W-1:0] wr_data;
  logic [IDX_W-1:0]  entry_idx;
  logic [IDX_W-1:0]  pc;
  logic [4:0]        sop;
  logic              gate_ok, inst_last, live;
  logic              ev_jump, ev_call, ev_ret;
  logic              call_ovf, ret_unf, push, pop;
  logic              start_go;
  logic [IDX_W-1:0]  jump_target, ret_idx;
  logic [LVL_W-1:0]  ras_level;
  logic              ras_full, ras_empty;

  shprog_loader #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .lock(running | run_start),
    .wr_en(commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .entry_idx(entry_idx), .upload_err(upload_err)
  );

  shprog_imem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_imem (
    .clk(clk), .wr_en(commit), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(pc), .rd_data(inst_word)
  );

  // Decode of the presented instruction
  assign sop         = sop_of(inst_word);
  assign inst_last   = is_final(inst_word);
  assign gate_ok     = ~cond_enabled(inst_word) | cond_pass;
  assign jump_target = inst_word[TGT_LSB +: IDX_W];
  assign live        = running & ~inst_last & gate_ok;
  assign ev_jump     = live && (sop == SOP_JUMP);
  assign ev_call     = live && (sop == SOP_CALL);
  assign ev_ret      = live && (sop == SOP_RETURN);
  assign call_ovf    = ev_call & ras_full;
  assign ret_unf     = ev_ret & ras_empty;
  assign push        = ev_call & ~ras_full;
  assign pop         = ev_ret & ~ras_empty;
  assign start_go    = run_start & ~running;

  shprog_ras #(.RAS_DEPTH(RAS_DEPTH), .IDX_W(IDX_W)) u_ras (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .push(push), .pop(pop),
    .push_data(pc + 1'b1), .top_data(ret_idx), .level(ras_level),
    .full(ras_full), .empty(ras_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      pc        <= '0;
      stack_err <= 1'b0;
    end else if (start_go) begin
      running <= 1'b1;
      pc      <= entry_idx;
    end else if (running) begin
      if (inst_last || call_ovf || ret_unf) begin
        running <= 1'b0;
        if (call_ovf || ret_unf) stack_err <= 1'b1;
      end else if (ev_jump || push) pc <= jump_target;
      else if (pop)                 pc <= ret_idx;
      else                          pc <= pc + 1'b1;
    end
  end

  assign inst_idx = pc;
endmodule

// File: rtl/shprog_seq_chk.sv
module shprog_seq_chk #(
  parameter int IDX_W     = 6,
  parameter int LVL_W     = 3,
  parameter int RAS_DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             run_start,
  input logic [IDX_W-1:0] inst_idx,
  input logic             commit,
  input logic             start_go,
  input logic [IDX_W-1:0] entry_idx,
  input logic [LVL_W-1:0] ras_level,
  input logic             call_ovf,
  input logic             ret_unf,
  input logic             ev_jump,
  input logic [IDX_W-1:0] jump_target,
  input logic             inst_last,
  input logic             stack_err,
  input logic             upload_err
);
  assert_no_write_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running || run_start) |-> !commit);

  assert_final_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && inst_last) |=> !running);

  assert_entry_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (running && inst_idx == $past(entry_idx)));

  assert_ras_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_level <= LVL_W'(RAS_DEPTH));

  assert_stack_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  assert_stack_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (call_ovf || ret_unf) |=> (!running && stack_err));

  assert_upload_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upload_err |=> upload_err);

  assert_jump_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> (running && inst_idx == $past(jump_target)));
endmodule

bind shprog_seq shprog_seq_chk #(.IDX_W(IDX_W), .LVL_W(LVL_W), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .run_start(run_start),
  .inst_idx(inst_idx), .commit(commit), .start_go(start_go),
  .entry_idx(entry_idx), .ras_level(ras_level), .call_ovf(call_ovf),
  .ret_unf(ret_unf), .ev_jump(ev_jump), .jump_target(jump_target),
  .inst_last(inst_last), .stack_err(stack_err), .upload_err(upload_err)
);

// File: tb/shprog_seq_tb.sv
`timescale 1ns/1ps
module shprog_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'd3;
  logic [31:0]  cmd_data = '0;
  logic         run_start = 1'b0;
  logic         cond_pass = 1'b0;
  logic         running;
  logic [5:0]   inst_idx;
  logic [127:0] inst_word;
  logic         upload_err;
  logic         stack_err;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int trace [16];
  int tlen;
  logic [127:0] first_word;
  int e [16];

  localparam logic [4:0] JMP = 5'h09, CAL = 5'h0B, RET = 5'h0C, NOP = 5'h00;

  always #4 clk = ~clk;

  shprog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .run_start(run_start), .cond_pass(cond_pass),
    .running(running), .inst_idx(inst_idx), .inst_word(inst_word),
    .upload_err(upload_err), .stack_err(stack_err)
  );

  // Instruction builder from the field positions in R2, R5, R6
  function automatic logic [127:0] mk(input logic [4:0] op, input bit cen,
                                      input int tgt, input bit last, input int tag);
    logic [31:0] w0, w1, w2, w3;
    w0 = {tag[11:0], 20'h0};
    w0[0] = op[4];
    w0[14] = cen;
    w1 = {op[3:0], 12'h0, tag[15:0]};
    w2 = {tag[15:0], 8'h0, tgt[5:0], 2'b00};
    w3 = {tag[15:0], 15'h0, last};
    return {w3, w2, w1, w0};
  endfunction

  function automatic logic [127:0] pat(input int i);
    return mk(NOP, 1'b0, i, 1'b1, 16'hA000 + i);
  endfunction

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_trace(input string rq, input int n);
    bit bad;
    bad = (tlen != n);
    for (int i = 0; i < n && i < 16; i++) if (trace[i] != e[i]) bad = 1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: actual len %0d first %0d expected len %0d first %0d",
               rq, tlen, trace[0], n, e[0]);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic put_inst(input logic [127:0] v);
    for (int k = 0; k < 4; k++) cmd(2'd1, v[32*k +: 32]);
  endtask

  task automatic load_at(input int idx, input logic [127:0] v);
    cmd(2'd0, idx);
    put_inst(v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // mode 0: plain; 1: host commands during run; 2: entry command in start cycle
  task automatic do_run(input int mode);
    run_start = 1'b1;
    if (mode == 2) begin cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 32'd20; end
    @(negedge clk);
    run_start = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd3;
    tlen = 0;
    while (running && tlen < 16) begin
      if (tlen == 0) first_word = inst_word;
      trace[tlen] = inst_idx;
      if (mode == 1) begin
        cmd_valid = (tlen >= 0 && tlen < 7);
        case (tlen)
          0: begin cmd_op = 2'd2; cmd_data = 32'd0; end
          1: begin cmd_op = 2'd0; cmd_data = 32'd3; end
          default: begin cmd_op = 2'd1; cmd_data = 32'hFFFF_FFFF; end
        endcase
      end
      tlen++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 running", running, 0);
    chk("R1 upload_err", upload_err, 0);
    chk("R1 stack_err", stack_err, 0);

    // Fill every index with one pointer command (R2, R3 auto-advance)
    cmd(2'd0, 0);
    for (int i = 0; i < 64; i++) put_inst(pat(i));
    chk("R9 no error in range", upload_err, 0);
    // Pointer now 64: next instruction is dropped
    put_inst(mk(NOP, 0, 0, 1, 16'hDEAD));
    chk("R9 upload_err set", upload_err, 1);

    // Exhaustive entry sweep (R4, R2, R5)
    for (int s = 0; s < 64; s++) begin
      cmd(2'd2, s);
      do_run(0);
      e = '{0: s, default: 0};
      chk_trace("R4/R5 entry sweep", 1);
      chk("R2 stored word", first_word, pat(s));
    end
    chk("R9 err still set", upload_err, 1);

    // R3: pointer command discards a partial instruction
    cmd(2'd0, 7);
    cmd(2'd1, 32'h1111_1111);
    cmd(2'd1, 32'h2222_2222);
    load_at(7, mk(NOP, 0, 0, 1, 16'hBEEF));
    cmd(2'd2, 7);
    do_run(0);
    chk("R3 restart word", first_word, mk(NOP, 0, 0, 1, 16'hBEEF));

    // Programs
    load_at(10, mk(NOP, 0, 0, 0, 1));
    put_inst(mk(JMP, 1, 14, 0, 2));        // 11
    put_inst(mk(NOP, 0, 0, 1, 3));         // 12
    load_at(20, mk(JMP, 0, 5, 0, 4));
    load_at(25, mk(CAL, 1, 2, 0, 5));
    put_inst(mk(NOP, 0, 0, 1, 6));         // 26
    load_at(2, mk(RET, 0, 0, 0, 7));
    load_at(30, mk(CAL, 0, 2, 0, 8));
    put_inst(mk(NOP, 0, 0, 1, 9));         // 31
    load_at(40, mk(CAL, 0, 50, 0, 10));
    put_inst(mk(NOP, 0, 0, 1, 11));        // 41
    load_at(45, mk(JMP, 0, 10, 1, 12));
    load_at(50, mk(CAL, 0, 52, 0, 13));
    put_inst(mk(RET, 0, 0, 0, 14));        // 51
    put_inst(mk(CAL, 0, 54, 0, 15));       // 52
    put_inst(mk(RET, 0, 0, 0, 16));        // 53
    put_inst(mk(CAL, 0, 56, 0, 17));       // 54
    put_inst(mk(RET, 0, 0, 0, 18));        // 55
    put_inst(mk(RET, 0, 0, 0, 19));        // 56
    load_at(60, mk(CAL, 0, 40, 0, 20));

    cond_pass = 1'b0;
    cmd(2'd2, 10); do_run(0);
    e = '{0: 10, 1: 11, 2: 12, default: 0};
    chk_trace("R6 conditional jump not taken", 3);
    cond_pass = 1'b1;
    do_run(0);
    e = '{0: 10, 1: 11, 2: 14, default: 0};
    chk_trace("R6 conditional jump taken", 3);
    cond_pass = 1'b0;
    cmd(2'd2, 20); do_run(0);
    e = '{0: 20, 1: 5, default: 0};
    chk_trace("R6 unconditional backward jump", 2);
    cmd(2'd2, 25); do_run(0);
    e = '{0: 25, 1: 26, default: 0};
    chk_trace("R7 conditional call not taken", 2);
    cmd(2'd2, 30); do_run(0);
    e = '{0: 30, 1: 2, 2: 31, default: 0};
    chk_trace("R7 call below entry and return", 3);
    cmd(2'd2, 40); do_run(0);
    e = '{0: 40, 1: 50, 2: 52, 3: 54, 4: 56, 5: 55, 6: 53, 7: 51, 8: 41, default: 0};
    chk_trace("R7 four-deep nesting", 9);
    chk("R7 no stack error", stack_err, 0);
    cmd(2'd2, 45); do_run(0);
    e = '{0: 45, default: 0};
    chk_trace("R11 final bit beats jump", 1);

    // R10: commands in the start cycle and during a run
    do_run(2);
    do_run(0);
    e = '{0: 45, default: 0};
    chk_trace("R10 entry command in start cycle ignored", 1);
    cmd(2'd2, 40); do_run(1);
    e = '{0: 40, 1: 50, 2: 52, 3: 54, 4: 56, 5: 55, 6: 53, 7: 51, 8: 41, default: 0};
    chk_trace("R10 run unaffected by commands", 9);
    do_run(0);
    e = '{0: 40, default: 0};
    chk("R10 entry kept", trace[0], e[0]);
    cmd(2'd2, 3); do_run(0);
    chk("R10 store kept", first_word, pat(3));

    // R8: overflow then underflow
    cmd(2'd2, 60); do_run(0);
    e = '{0: 60, 1: 40, 2: 50, 3: 52, 4: 54, default: 0};
    chk_trace("R8 call on full stack halts", 5);
    chk("R8 stack_err after overflow", stack_err, 1);
    repeat (3) @(negedge clk);
    chk("R8 stack_err sticky", stack_err, 1);
    do_reset();
    chk("R1 stack_err cleared", stack_err, 0);
    cmd(2'd2, 51); do_run(0);
    e = '{0: 51, default: 0};
    chk_trace("R8 return on empty stack halts", 1);
    chk("R8 stack_err after underflow", stack_err, 1);

    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule